// File: doc/BRIEF.md
# I2C Bus Event Trace Encoder

This block listens passively to the clock and data wires of a display data channel and to a hot-plug-detect wire. It never drives any of them. It rebuilds each byte from the data level seen at every clock rise, and it tracks the START and STOP framing around that byte and the acknowledge that follows it. For each event it produces one 32-bit trace word. The word carries a type tag, the time since the previous word, the byte and the acknowledge bit. Framing faults, stalled transfers and hot-plug edges go into the same stream.

Every input is already synchronous to `clk`. The block advances only in cycles where `smp_en` is high. Time is counted in ticks, and one tick is `cfg_tick_len` sampled cycles. A 5-bit class mask chooses which exception events become records. Each emitted exception record also raises a one-cycle flag for its class. A downstream writer stores the records.

Top module: `i2c_trace_encoder`

## Requirements
- R1: A record is `rec_data` qualified by `rec_valid`. Bits 31..29 hold the type, bits 28..9 the delta time, bits 8..1 the byte, and bit 0 the acknowledge bit (0 = ACK, 1 = NAK).
- R2: A completed byte is tagged by its framing. Type 1 is a byte after START, type 0 a plain byte, type 2 a byte followed by STOP, and type 3 a byte both after START and followed by STOP. For types 1 and 3, data bit 0 is the read flag (1 = read).
- R3: START is SDA falling while SCL stays high, and STOP is SDA rising while SCL stays high. SDA is sampled at each SCL rise, most significant bit first, and the ninth rise gives the acknowledge bit. A byte's record is emitted once the framing that follows it is known.
- R4: A STOP that arrives while a byte is only partly received gives type 4. Its data field holds the bits received so far, right-aligned, and bit 0 is 0. Its class is mask bit 2.
- R5: A START that arrives while a byte is in flight gives type 5 with the captured bits. If all 8 data bits were captured, bit 0 is 1 and the class is mask bit 1. If fewer were captured, bit 0 is 0 and the class is mask bit 0.
- R6: Inside a transfer with no completed byte on hold, SCL that stays unchanged for more than `cfg_timeout` ticks gives type 6 and returns the block to idle. Bit 0 is 1 with data 0 when no bit was captured. Otherwise bit 0 is 0 and the data field holds the partial bits. Its class is mask bit 3.
- R7: Each edge of `hpd_in` gives type 7 with data 0. Bit 0 is the new level (1 = rise). Its class is mask bit 4. When it collides with a bus record, it is emitted in a later cycle.
- R8: A record of types 4 to 7, and its flag, appear only when its class bit in `cfg_dump_mask` is set. Types 0 to 3 are always emitted.
- R9: The delta field counts ticks since the previous emitted record and saturates at `DELTA_MAX`. A tick is `cfg_tick_len` cycles with `smp_en` high, and a length of 0 acts as 1.
- R10: `evt_irq` pulses the bit of an emitted record's class in the same cycle as `rec_valid`, with at most one bit set.
- R11: While `smp_en` is low, no state advances and no record appears.
- R12: After reset, `rec_valid` and `evt_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample enable; the block advances only when high |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| hpd_in | input | 1 | Hot-plug-detect level |
| cfg_timeout | input | TO_W | Stall threshold in ticks |
| cfg_dump_mask | input | 5 | Exception class enables |
| cfg_tick_len | input | TICK_W | Sampled cycles per tick |
| rec_data | output | 32 | Trace record |
| rec_valid | output | 1 | Record strobe |
| evt_irq | output | 5 | Per-class event flags |

## Verification
The bench sets `DELTA_MAX` to 60, `TO_W` to 8 and `TICK_W` to 4. It drives a 2-cycle tick and a 6-tick timeout. Because the saturation limit is small, the delta clamp can be reached in a few hundred cycles rather than millions. Because the tick and threshold are short, a stalled transfer trips the timeout in a few dozen cycles, while ordinary bit timing with 4-cycle half periods stays well clear of it. The delta value between two hot-plug records spaced 40 cycles apart is also checked.

// File: rtl/i2c_trace_encoder.sv
module i2c_trace_encoder #(
  parameter int DELTA_MAX = 1048575,
  parameter int TO_W      = 16,
  parameter int TICK_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              hpd_in,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic [4:0]        cfg_dump_mask,
  input  logic [TICK_W-1:0] cfg_tick_len,
  output logic [31:0]       rec_data,
  output logic              rec_valid,
  output logic [4:0]        evt_irq
);
  localparam int DW = 20;
  localparam logic [DW-1:0] DMAX = DW'(DELTA_MAX);
  localparam logic [2:0] T_DATA = 3'd0, T_SDATA = 3'd1, T_DSTOP = 3'd2, T_SDSTOP = 3'd3,
                         T_ABSTOP = 3'd4, T_ABSTART = 3'd5, T_TMO = 3'd6, T_HPD = 3'd7;

  logic scl_q, sda_q, hpd_q;
  logic busy, first_f, pend, pend_first, pend_ack, hpd_pend, hpd_lvl;
  logic [7:0] sh, pend_data;
  logic [3:0] bitcnt;
  logic [TO_W-1:0] to_cnt;
  logic [TICK_W-1:0] tdiv;
  logic [DW-1:0] dcnt;

  logic [TICK_W-1:0] tick_lim;
  logic tick, scl_rise, scl_fall, start_c, stop_c, partial, to_arm, to_fire;
  logic ev_valid, ev_ack, bus_emit, hpd_emit, any_emit;
  logic [2:0] ev_type;
  logic [7:0] ev_data;
  logic [4:0] ev_cls;

  assign tick_lim = (cfg_tick_len == '0) ? TICK_W'(1) : cfg_tick_len;
  assign tick     = smp_en && (tdiv >= tick_lim - TICK_W'(1));
  assign scl_rise = smp_en && !scl_q && scl_in;
  assign scl_fall = smp_en && scl_q && !scl_in;
  assign start_c  = smp_en && scl_q && scl_in && sda_q && !sda_in;
  assign stop_c   = smp_en && scl_q && scl_in && !sda_q && sda_in;
  assign partial  = (bitcnt >= 4'd2) || (bitcnt == 4'd1 && !pend);
  assign to_arm   = busy && !pend;
  assign to_fire  = tick && to_arm && !scl_rise && !scl_fall && !start_c && !stop_c
                    && (to_cnt >= cfg_timeout);

  always_comb begin
    ev_valid = 1'b0;
    ev_type  = T_DATA;
    ev_data  = 8'h00;
    ev_ack   = 1'b0;
    ev_cls   = 5'b00000;
    if (start_c && busy && partial) begin
      ev_valid = 1'b1;
      ev_type  = T_ABSTART;
      ev_data  = sh;
      ev_ack   = (bitcnt == 4'd8);
      ev_cls   = (bitcnt == 4'd8) ? 5'b00010 : 5'b00001;
    end else if (start_c && pend) begin
      ev_valid = 1'b1;
      ev_type  = pend_first ? T_SDATA : T_DATA;
      ev_data  = pend_data;
      ev_ack   = pend_ack;
    end else if (stop_c && busy && partial) begin
      ev_valid = 1'b1;
      ev_type  = T_ABSTOP;
      ev_data  = sh;
      ev_cls   = 5'b00100;
    end else if (stop_c && pend) begin
      ev_valid = 1'b1;
      ev_type  = pend_first ? T_SDSTOP : T_DSTOP;
      ev_data  = pend_data;
      ev_ack   = pend_ack;
    end else if (scl_rise && pend && bitcnt == 4'd1) begin
      ev_valid = 1'b1;
      ev_type  = pend_first ? T_SDATA : T_DATA;
      ev_data  = pend_data;
      ev_ack   = pend_ack;
    end else if (to_fire) begin
      ev_valid = 1'b1;
      ev_type  = T_TMO;
      ev_data  = sh;
      ev_ack   = (bitcnt == 4'd0);
      ev_cls   = 5'b01000;
    end
  end

  assign bus_emit = ev_valid && ((ev_cls == 5'b0) || |(ev_cls & cfg_dump_mask));
  assign hpd_emit = smp_en && hpd_pend && !bus_emit && cfg_dump_mask[4];
  assign any_emit = bus_emit || hpd_emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; hpd_q <= 1'b0;
      busy <= 1'b0; first_f <= 1'b0; pend <= 1'b0; pend_first <= 1'b0; pend_ack <= 1'b0;
      pend_data <= '0; sh <= '0; bitcnt <= '0; to_cnt <= '0; tdiv <= '0; dcnt <= '0;
      hpd_pend <= 1'b0; hpd_lvl <= 1'b0;
    end else if (smp_en) begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      hpd_q <= hpd_in;
      tdiv  <= tick ? '0 : tdiv + TICK_W'(1);
      if (any_emit)                 dcnt <= '0;
      else if (tick && dcnt < DMAX) dcnt <= dcnt + DW'(1);
      if (hpd_in != hpd_q && cfg_dump_mask[4]) begin
        hpd_pend <= 1'b1;
        hpd_lvl  <= hpd_in;
      end else if (hpd_emit || !cfg_dump_mask[4]) begin
        hpd_pend <= 1'b0;
      end
      if (start_c || stop_c || to_fire) begin
        busy    <= start_c;
        first_f <= start_c;
        pend    <= 1'b0;
        bitcnt  <= '0;
        sh      <= '0;
        to_cnt  <= '0;
      end else if (busy) begin
        if (scl_rise) begin
          to_cnt <= '0;
          if (bitcnt == 4'd8) begin
            pend       <= 1'b1;
            pend_data  <= sh;
            pend_ack   <= sda_in;
            pend_first <= first_f;
            first_f    <= 1'b0;
            bitcnt     <= '0;
            sh         <= '0;
          end else begin
            sh     <= {sh[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd1) pend <= 1'b0;
          end
        end else if (scl_fall) begin
          to_cnt <= '0;
        end else if (tick && to_arm) begin
          to_cnt <= to_cnt + TO_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_data  <= '0;
      evt_irq   <= '0;
    end else begin
      rec_valid <= any_emit;
      if (bus_emit) begin
        rec_data <= {ev_type, dcnt, ev_data, ev_ack};
        evt_irq  <= ev_cls & cfg_dump_mask;
      end else if (hpd_emit) begin
        rec_data <= {T_HPD, dcnt, 8'h00, hpd_lvl};
        evt_irq  <= 5'b10000;
      end else begin
        evt_irq  <= '0;
      end
    end
  end

  AST_REC_NEEDS_SMP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(smp_en)); // R11
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_irq)); // R10
  AST_FLAG_HAS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_irq) |-> rec_valid); // R10
  AST_HPD_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_data[31:29] == T_HPD) |-> rec_data[8:1] == 8'h00); // R7
  AST_DELTA_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_data[28:9] <= DMAX); // R9
  AST_TIMEOUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_data[31:29] == T_TMO) |-> evt_irq[3]); // R6
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_irq & ~$past(cfg_dump_mask)) == 5'b0); // R8
endmodule

// File: tb/i2c_trace_encoder_tb.sv
module i2c_trace_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;
  localparam int DMAXV = 60;

  logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b1;
  logic scl = 1'b1, sda = 1'b1, hpd = 1'b0;
  logic [7:0] cfg_timeout = 8'd6;
  logic [4:0] cfg_mask = 5'h1f;
  logic [3:0] cfg_tick = 4'd2;
  logic [31:0] rec_data;
  logic rec_valid;
  logic [4:0] evt_irq;

  int total = 0, bad = 0, rec_n = 0, irq_seen_n = 0;
  logic [31:0] rec_log [0:255];
  logic [4:0]  irq_log [0:255];

  i2c_trace_encoder #(.DELTA_MAX(DMAXV), .TO_W(8), .TICK_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .scl_in(scl), .sda_in(sda), .hpd_in(hpd),
    .cfg_timeout(cfg_timeout), .cfg_dump_mask(cfg_mask), .cfg_tick_len(cfg_tick),
    .rec_data(rec_data), .rec_valid(rec_valid), .evt_irq(evt_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rec_valid && rec_n < 256) begin
      rec_log[rec_n] = rec_data;
      irq_log[rec_n] = evt_irq;
      rec_n = rec_n + 1;
    end
    if (rst_n && evt_irq != 5'b0) irq_seen_n = irq_seen_n + 1;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_rec(input int idx, input logic [2:0] ty, input logic [7:0] d,
                         input logic a, input logic [4:0] irq, input string req);
    logic [31:0] exp;
    exp = {ty, 20'd0, d, a};
    if (idx >= rec_n) chk(1'b0, req, "missing record", 32'(rec_n), 32'(idx));
    else begin
      chk({rec_log[idx][31:29], rec_log[idx][8:0]} == {ty, d, a}, req, "record",
          rec_log[idx] & 32'hE00001FF, exp);
      chk(irq_log[idx] == irq, req, "flags", 32'(irq_log[idx]), 32'(irq));
    end
  endtask

  task automatic bstart();  sda = 0; wcyc(H); scl = 0; wcyc(H); endtask
  task automatic bstop();   sda = 0; wcyc(H); scl = 1; wcyc(H); sda = 1; wcyc(H); endtask
  task automatic brestart(); sda = 1; wcyc(H); scl = 1; wcyc(H); sda = 0; wcyc(H); scl = 0; wcyc(H); endtask
  task automatic bbit(input logic b); sda = b; wcyc(H); scl = 1; wcyc(H); scl = 0; endtask
  task automatic bbyte(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) bbit(b[i]);
    bbit(ack);
  endtask

  task automatic t_reset();
    chk(rec_valid == 1'b0, "R12", "rec_valid after reset", 32'(rec_valid), 0);
    chk(evt_irq == 5'b0, "R12", "evt_irq after reset", 32'(evt_irq), 0);
  endtask

  task automatic t_write();
    int b = rec_n;
    bstart(); bbyte(8'hA0, 0); bbyte(8'h10, 0); bbyte(8'h55, 1); bstop(); wcyc(10);
    chk(rec_n - b == 3, "R2", "write record count", 32'(rec_n - b), 3);
    chk_rec(b, 3'd1, 8'hA0, 0, 5'b0, "R2 R3");
    chk_rec(b + 1, 3'd0, 8'h10, 0, 5'b0, "R2");
    chk_rec(b + 2, 3'd2, 8'h55, 1, 5'b0, "R1 R2");
  endtask

  task automatic t_single();
    int b = rec_n;
    bstart(); bbyte(8'hA1, 1); bstop(); wcyc(10);
    chk_rec(b, 3'd3, 8'hA1, 1, 5'b0, "R2");
    chk(rec_log[b][1] == 1'b1, "R2", "read flag", 32'(rec_log[b][1]), 1);
  endtask

  task automatic t_restart();
    int b = rec_n;
    bstart(); bbyte(8'hA0, 0); bbyte(8'h00, 0); brestart(); bbyte(8'hA1, 0); bbyte(8'h77, 1);
    bstop(); wcyc(10);
    chk(rec_n - b == 4, "R3", "restart record count", 32'(rec_n - b), 4);
    chk_rec(b, 3'd1, 8'hA0, 0, 5'b0, "R3");
    chk_rec(b + 1, 3'd0, 8'h00, 0, 5'b0, "R3");
    chk_rec(b + 2, 3'd1, 8'hA1, 0, 5'b0, "R3");
    chk_rec(b + 3, 3'd2, 8'h77, 1, 5'b0, "R3");
  endtask

  task automatic t_abstop();
    int b = rec_n;
    bstart(); bbyte(8'hA0, 0); bbit(1); bbit(0); bbit(1); bstop(); wcyc(10);
    chk_rec(b, 3'd1, 8'hA0, 0, 5'b0, "R4");
    chk_rec(b + 1, 3'd4, 8'h0A, 0, 5'b00100, "R4 R10");
  endtask

  task automatic t_abstart0();
    int b = rec_n;
    bstart(); bbit(1); bbit(1); brestart(); bbyte(8'hA0, 0); bstop(); wcyc(10);
    chk_rec(b, 3'd5, 8'h07, 0, 5'b00001, "R5");
    chk_rec(b + 1, 3'd3, 8'hA0, 0, 5'b0, "R5");
  endtask

  task automatic t_abstart1();
    int b = rec_n;
    logic [7:0] v = 8'h3D;
    bstart();
    for (int i = 7; i >= 1; i--) bbit(v[i]);
    sda = 1; wcyc(H); scl = 1; wcyc(H); sda = 0; wcyc(H); scl = 0; wcyc(H);
    bbyte(8'hA0, 0); bstop(); wcyc(10);
    chk_rec(b, 3'd5, 8'h3D, 1, 5'b00010, "R5");
    chk_rec(b + 1, 3'd3, 8'hA0, 0, 5'b0, "R5");
  endtask

  task automatic t_tmo_partial();
    int b = rec_n;
    bstart(); bbit(1); bbit(0); wcyc(60); bstop(); wcyc(10);
    chk(rec_n - b == 1, "R6", "timeout record count", 32'(rec_n - b), 1);
    chk_rec(b, 3'd6, 8'h02, 0, 5'b01000, "R6");
  endtask

  task automatic t_tmo_empty();
    int b = rec_n;
    bstart(); wcyc(60); bstop(); wcyc(10);
    chk(rec_n - b == 1, "R6", "empty timeout count", 32'(rec_n - b), 1);
    chk_rec(b, 3'd6, 8'h00, 1, 5'b01000, "R6");
  endtask

  task automatic t_hpd();
    int b = rec_n;
    hpd = 1; wcyc(10); hpd = 0; wcyc(10);
    chk_rec(b, 3'd7, 8'h00, 1, 5'b10000, "R7");
    chk_rec(b + 1, 3'd7, 8'h00, 0, 5'b10000, "R7");
  endtask

  task automatic t_mask();
    int b = rec_n;
    int s = irq_seen_n;
    cfg_mask = 5'h00;
    bstart(); bbyte(8'hA0, 0); bbit(1); bbit(0); bbit(1); bstop(); wcyc(10);
    hpd = 1; wcyc(10); hpd = 0; wcyc(10);
    chk(rec_n - b == 1, "R8", "masked record count", 32'(rec_n - b), 1);
    chk_rec(b, 3'd1, 8'hA0, 0, 5'b0, "R8");
    chk(irq_seen_n == s, "R8", "masked flags", 32'(irq_seen_n - s), 0);
    cfg_mask = 5'h1f; wcyc(5);
  endtask

  task automatic t_smp_off();
    int b = rec_n;
    smp_en = 0; wcyc(3); hpd = 1; wcyc(10); hpd = 0; wcyc(5); smp_en = 1; wcyc(10);
    chk(rec_n == b, "R11", "records while disabled", 32'(rec_n - b), 0);
  endtask

  task automatic t_saturate();
    int b = rec_n;
    wcyc(300); hpd = 1; wcyc(10);
    chk(rec_n - b == 1, "R9", "saturation record count", 32'(rec_n - b), 1);
    if (rec_n > b) chk(rec_log[b][28:9] == 20'(DMAXV), "R9", "saturated delta",
                       32'(rec_log[b][28:9]), DMAXV);
    hpd = 0; wcyc(10);
  endtask

  task automatic t_delta();
    int b;
    wcyc(20);
    b = rec_n;
    hpd = 1; wcyc(40); hpd = 0; wcyc(10);
    chk(rec_n - b == 2, "R9", "delta pair count", 32'(rec_n - b), 2);
    if (rec_n > b + 1) chk(rec_log[b + 1][28:9] >= 20'd19 && rec_log[b + 1][28:9] <= 20'd20,
                           "R9", "delta over 40 cycles", 32'(rec_log[b + 1][28:9]), 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wcyc(5); rst_n = 1; wcyc(2);
    t_reset();
    t_write();
    t_single();
    t_restart();
    t_abstop();
    t_abstart0();
    t_abstart1();
    t_tmo_partial();
    t_tmo_empty();
    t_hpd();
    t_mask();
    t_smp_off();
    t_saturate();
    t_delta();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule